// File: doc/BRIEF.md
# SMBus Slave Register Access Parser

The block sits behind an SMBus slave byte engine that has already matched the device address. It receives the incoming byte stream together with start, repeated-start and stop markers, and assembles register access requests. A request frame opens with a command code. A byte count follows only when the command code marks a block transfer. Then come a command byte, two address bytes that together form a 14-bit doubleword index, and, for writes, four data bytes with the least significant byte first.

A well-formed write frame produces a one-cycle write strobe on an internal register bus once the stop condition arrives. It carries the dword index, the per-lane byte enables from the command byte and the 32-bit write data. A well-formed read frame produces a one-cycle read strobe at its stop and captures the returned data in the same cycle. A later read transaction then streams back a response: an optional byte count, a status byte, the two address bytes and four data bytes. A malformed frame is dropped. It raises a sticky write-error flag that appears in the next status byte sent.

Top module: `smb_csr_slave`

## Requirements
- R1: Command code bit 7 set marks a block transfer, and the byte right after the command code is then taken as the byte count. With bit 7 clear, no count byte is expected and the next byte is the command byte.
- R2: A frame whose command byte has bit 4 clear and which carries exactly seven bytes after the command code or count produces `reg_wr_o` for exactly one cycle. The strobe comes in the cycle after the stop is sampled. At that point `reg_be_o` equals command byte bits 3:0, and `reg_wdata_o` holds the four data bytes, the first received byte in bits 7:0.
- R3: The dword index is formed from the address-low byte as bits 7:0 and the address-upper byte bits 5:0 as bits 13:8. Upper-byte bits 7:6 never reach `reg_addr_o`, and they are returned as zero in the response.
- R4: In a block transfer, a byte count that differs from the number of bytes received after it drops the request, and the write-error flag is set. A write needs 7 bytes and a read setup needs 3. A frame whose operation bit disagrees with its length is dropped the same way.
- R5: A frame ended by stop before all of its bytes have arrived produces no strobe and sets the write-error flag.
- R6: A frame with command byte bit 4 set and exactly three bytes (command, address low, address upper) produces `reg_rd_o` for one cycle after the stop. `reg_rdata_i` and `reg_err_i` are captured in that same cycle.
- R7: A read transaction returns bytes in this order: the count 7 (block only), status, address low, address upper, then data bits 7:0 up to 31:24. Bytes requested past the end are 0x00. `tx_byte_o` is 0x00 outside a response.
- R8: The status byte holds the captured byte enables in bits 3:0, a 1 in bit 4, the read-error flag in bit 5, the write-error flag in bit 6 and 0 in bit 7.
- R9: If `reg_err_i` was high during the read strobe, the read-error bit is set and all returned data bytes are zero. Data lanes whose enable bit was 0 also return zero.
- R10: The write-error flag stays set until a status byte has been transmitted, and is clear in the status of the following response.
- R11: A start condition after any byte beyond the command code aborts the frame with no strobe and no error, and the parser then waits for a new command code. A repeated start in the read direction directly after the command code begins a response.
- R12: After reset both strobes are low, `reg_addr_o`, `reg_be_o` and `reg_wdata_o` are zero, and the write-error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received byte valid for one cycle |
| rx_byte_i | input | 8 | Received byte |
| start_i | input | 1 | Start or repeated start seen |
| start_rd_i | input | 1 | Direction of the transaction opened by `start_i` (1 = master reads) |
| stop_i | input | 1 | Stop condition seen |
| tx_req_i | input | 1 | Current transmit byte consumed, advance to the next |
| tx_byte_o | output | 8 | Byte to transmit |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 14 | Dword register index |
| reg_be_o | output | 4 | Byte-lane enables |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid during `reg_rd_o` |
| reg_err_i | input | 1 | Read failed or unmapped, valid during `reg_rd_o` |

## Verification
A parser that is in the wrong frame position shows up at the stop that closes the frame. The strobe appears or fails to appear in the very next cycle, or the data lanes and address arrive shifted by a byte. A wrong error flag or captured read result stays hidden until the next read transaction, where the status byte exposes it one byte into the response. The stimulus therefore follows every malformed frame with a response read and checks the status bits there. It also reads the status a second time to show that the error flag was cleared.

// File: rtl/smb_csr_pkg.sv
`timescale 1ns/1ps
package smb_csr_pkg;
  // command/status byte bit positions
  localparam int CMD_OP   = 4;
  localparam int CMD_RERR = 5;
  localparam int CMD_WERR = 6;
  // bytes after count: command, address low, address upper
  localparam int HDR_LEN  = 3;

  typedef enum logic [1:0] {
    PS_IDLE,   // waiting for command code
    PS_CNT,    // waiting for block byte count
    PS_BODY,   // command, address, data bytes
    PS_TX      // response being read out
  } pstate_e;
endpackage

// File: rtl/smb_csr_rx.sv
`timescale 1ns/1ps
module smb_csr_rx
  import smb_csr_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int BLK_BIT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_byte_i,
  input  logic                start_i,
  input  logic                start_rd_i,
  input  logic                stop_i,
  output logic                tx_mode_o,
  output logic                tx_begin_o,
  output logic                blk_o,
  output logic                err_set_o,
  output logic                wr_o,
  output logic                rd_o,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic [DATA_W-1:0]   wdata_o
);
  localparam int NLANE  = DATA_W / 8;
  localparam int HI_W   = ADDR_W - 8;
  localparam int WR_LEN = HDR_LEN + NLANE;
  localparam int RD_LEN = HDR_LEN;
  localparam int POS_W  = $clog2(WR_LEN + 2);
  localparam logic [POS_W-1:0] POS_MAX = POS_W'(WR_LEN + 1);

  pstate_e           state_q;
  logic              blk_q, has_cnt_q, op_q;
  logic [7:0]        cnt_q;
  logic [POS_W-1:0]  pos_q;
  logic [NLANE-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  logic in_frame, started, mid, wr_ok, rd_ok;

  always_comb begin
    in_frame   = (state_q == PS_CNT) || (state_q == PS_BODY);
    started    = has_cnt_q || (pos_q != '0);
    mid        = in_frame && started;
    tx_begin_o = start_i && start_rd_i && !mid;
    wr_ok = !op_q && (pos_q == POS_W'(WR_LEN)) && (!blk_q || cnt_q == 8'(WR_LEN));
    rd_ok =  op_q && (pos_q == POS_W'(RD_LEN)) && (!blk_q || cnt_q == 8'(RD_LEN));
  end

  assign tx_mode_o = (state_q == PS_TX);
  assign blk_o     = blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= PS_IDLE;
      blk_q     <= 1'b0;
      has_cnt_q <= 1'b0;
      op_q      <= 1'b0;
      cnt_q     <= '0;
      pos_q     <= '0;
      be_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      err_set_o <= 1'b0;
      wr_o      <= 1'b0;
      rd_o      <= 1'b0;
      addr_o    <= '0;
      be_o      <= '0;
      wdata_o   <= '0;
    end else begin
      wr_o      <= 1'b0;
      rd_o      <= 1'b0;
      err_set_o <= 1'b0;
      if (start_i) begin
        // mid-frame start aborts silently
        state_q <= tx_begin_o ? PS_TX : PS_IDLE;
      end else if (stop_i) begin
        state_q <= PS_IDLE;
        if (mid) begin
          if (wr_ok) begin
            wr_o    <= 1'b1;
            addr_o  <= addr_q;
            be_o    <= be_q;
            wdata_o <= data_q;
          end else if (rd_ok) begin
            rd_o   <= 1'b1;
            addr_o <= addr_q;
            be_o   <= be_q;
          end else begin
            err_set_o <= 1'b1;
          end
        end
      end else if (rx_valid_i) begin
        unique case (state_q)
          PS_IDLE: begin
            blk_q     <= rx_byte_i[BLK_BIT];
            has_cnt_q <= 1'b0;
            pos_q     <= '0;
            state_q   <= rx_byte_i[BLK_BIT] ? PS_CNT : PS_BODY;
          end
          PS_CNT: begin
            cnt_q     <= rx_byte_i;
            has_cnt_q <= 1'b1;
            state_q   <= PS_BODY;
          end
          PS_BODY: begin
            if (pos_q == POS_W'(0)) begin
              be_q <= rx_byte_i[NLANE-1:0];
              op_q <= rx_byte_i[CMD_OP];
            end
            if (pos_q == POS_W'(1)) addr_q[7:0] <= rx_byte_i;
            if (pos_q == POS_W'(2)) addr_q[ADDR_W-1:8] <= rx_byte_i[HI_W-1:0];
            for (int l = 0; l < NLANE; l++) begin
              if (pos_q == POS_W'(HDR_LEN + l)) data_q[8*l +: 8] <= rx_byte_i;
            end
            if (pos_q != POS_MAX) pos_q <= pos_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_csr_tx.sv
`timescale 1ns/1ps
module smb_csr_tx
  import smb_csr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tx_begin_i,
  input  logic                blk_i,
  input  logic                tx_mode_i,
  input  logic                tx_req_i,
  input  logic                err_set_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic                rerr_i,
  output logic [7:0]          tx_byte_o
);
  localparam int NLANE   = DATA_W / 8;
  localparam int RSP_LEN = HDR_LEN + NLANE;
  localparam int IDX_W   = $clog2(RSP_LEN + 2);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(RSP_LEN + 1);

  logic [IDX_W-1:0]  idx_q;
  logic              werr_q, rerr_q;
  logic [NLANE-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [7:0]        status;
  logic              adv;

  assign adv = tx_mode_i && tx_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      werr_q <= 1'b0;
      rerr_q <= 1'b0;
      be_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (tx_begin_i)                 idx_q <= blk_i ? IDX_W'(0) : IDX_W'(1);
      else if (adv && idx_q != IDX_END) idx_q <= idx_q + 1'b1;

      // a new error wins over the clear
      if (err_set_i)                            werr_q <= 1'b1;
      else if (adv && idx_q == IDX_W'(1))       werr_q <= 1'b0;

      if (rd_i) begin
        addr_q <= addr_i;
        be_q   <= be_i;
        rerr_q <= rerr_i;
        for (int l = 0; l < NLANE; l++) begin
          data_q[8*l +: 8] <= (rerr_i || !be_i[l]) ? 8'h00 : rdata_i[8*l +: 8];
        end
      end
    end
  end

  always_comb begin
    status = '0;
    status[NLANE-1:0] = be_q;
    status[CMD_OP]    = 1'b1;
    status[CMD_RERR]  = rerr_q;
    status[CMD_WERR]  = werr_q;
  end

  always_comb begin
    tx_byte_o = 8'h00;
    if (idx_q == IDX_W'(0)) tx_byte_o = 8'(RSP_LEN);
    if (idx_q == IDX_W'(1)) tx_byte_o = status;
    if (idx_q == IDX_W'(2)) tx_byte_o = addr_q[7:0];
    if (idx_q == IDX_W'(3)) tx_byte_o = 8'(addr_q[ADDR_W-1:8]);
    for (int l = 0; l < NLANE; l++) begin
      if (idx_q == IDX_W'(HDR_LEN + 1 + l)) tx_byte_o = data_q[8*l +: 8];
    end
    if (!tx_mode_i) tx_byte_o = 8'h00;
  end
endmodule

// File: rtl/smb_csr_slave.sv
`timescale 1ns/1ps
module smb_csr_slave #(
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 32,
  parameter int BLK_BIT = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_byte_i,
  input  logic                start_i,
  input  logic                start_rd_i,
  input  logic                stop_i,
  input  logic                tx_req_i,
  output logic [7:0]          tx_byte_o,
  output logic                reg_wr_o,
  output logic                reg_rd_o,
  output logic [ADDR_W-1:0]   reg_addr_o,
  output logic [DATA_W/8-1:0] reg_be_o,
  output logic [DATA_W-1:0]   reg_wdata_o,
  input  logic [DATA_W-1:0]   reg_rdata_i,
  input  logic                reg_err_i
);
  logic tx_mode, tx_begin, blk, err_set;

  smb_csr_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_BIT(BLK_BIT)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_valid_i (rx_valid_i),
    .rx_byte_i  (rx_byte_i),
    .start_i    (start_i),
    .start_rd_i (start_rd_i),
    .stop_i     (stop_i),
    .tx_mode_o  (tx_mode),
    .tx_begin_o (tx_begin),
    .blk_o      (blk),
    .err_set_o  (err_set),
    .wr_o       (reg_wr_o),
    .rd_o       (reg_rd_o),
    .addr_o     (reg_addr_o),
    .be_o       (reg_be_o),
    .wdata_o    (reg_wdata_o)
  );

  smb_csr_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_begin_i (tx_begin),
    .blk_i      (blk),
    .tx_mode_i  (tx_mode),
    .tx_req_i   (tx_req_i),
    .err_set_i  (err_set),
    .rd_i       (reg_rd_o),
    .addr_i     (reg_addr_o),
    .be_i       (reg_be_o),
    .rdata_i    (reg_rdata_i),
    .rerr_i     (reg_err_i),
    .tx_byte_o  (tx_byte_o)
  );
endmodule

// File: rtl/smb_csr_slave_chk.sv
`timescale 1ns/1ps
module smb_csr_slave_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                stop_i,
  input logic                reg_wr_o,
  input logic                reg_rd_o,
  input logic [ADDR_W-1:0]   reg_addr_o,
  input logic [DATA_W/8-1:0] reg_be_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o)); // R2
  AST_WR_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> $past(stop_i)); // R2
  AST_WR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o); // R2
  AST_RD_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |-> $past(stop_i)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(stop_i) |-> ($stable(reg_addr_o) && $stable(reg_be_o))); // R3
  AST_START_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!reg_wr_o && !reg_rd_o)); // R11
endmodule

bind smb_csr_slave smb_csr_slave_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .stop_i     (stop_i),
  .reg_wr_o   (reg_wr_o),
  .reg_rd_o   (reg_rd_o),
  .reg_addr_o (reg_addr_o),
  .reg_be_o   (reg_be_o)
);

// File: tb/smb_csr_slave_tb.sv
`timescale 1ns/1ps
module smb_csr_slave_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_byte_i = 8'h00;
  logic        start_i = 1'b0, start_rd_i = 1'b0, stop_i = 1'b0, tx_req_i = 1'b0;
  logic [7:0]  tx_byte_o;
  logic        reg_wr_o, reg_rd_o, reg_err_i;
  logic [13:0] reg_addr_o;
  logic [3:0]  reg_be_o;
  logic [31:0] reg_wdata_o, reg_rdata_i;

  int total = 0, bad = 0;
  bit done = 0;
  logic        seen_wr, seen_rd;
  logic [13:0] cap_addr;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;
  logic [7:0]  rsp [9];

  always #5 clk_i = ~clk_i;

  function automatic logic [31:0] model_rd(input logic [13:0] a);
    return {a, 2'b10, 16'h5AC3};
  endfunction
  assign reg_rdata_i = model_rd(reg_addr_o);
  assign reg_err_i   = (reg_addr_o == 14'h3FFF);

  smb_csr_slave u_dut (.*);

  typedef struct packed {
    logic        blk;
    logic [7:0]  cnt;
    logic [3:0]  n;
    logic [7:0]  cmd;
    logic [7:0]  al;
    logic [7:0]  au;
    logic [31:0] data;
    logic        exp_wr;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 8'd7, 4'd7, 8'h0F, 8'h01, 8'h00, 32'h11223344, 1'b1}, // block write
    '{1'b0, 8'd0, 4'd7, 8'h05, 8'h34, 8'hD2, 32'hCAFEF00D, 1'b1}, // upper bits 7:6 set
    '{1'b1, 8'd6, 4'd7, 8'h0F, 8'h10, 8'h00, 32'h01020304, 1'b0}, // count mismatch
    '{1'b0, 8'd0, 4'd5, 8'h0F, 8'h11, 8'h00, 32'h0A0B0C0D, 1'b0}, // short frame
    '{1'b1, 8'd7, 4'd7, 8'h1F, 8'h12, 8'h00, 32'h55667788, 1'b0}, // read op with data
    '{1'b0, 8'd0, 4'd7, 8'h08, 8'hFF, 8'h3F, 32'hDEADBEEF, 1'b1}  // top index, one lane
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i); rx_valid_i = 1'b1; rx_byte_i = b;
    @(negedge clk_i); rx_valid_i = 1'b0;
  endtask

  task automatic do_start(input logic rd);
    @(negedge clk_i); start_i = 1'b1; start_rd_i = rd;
    @(negedge clk_i); start_i = 1'b0; start_rd_i = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk_i); stop_i = 1'b1;
    @(negedge clk_i); stop_i = 1'b0;
    seen_wr = reg_wr_o; seen_rd = reg_rd_o;
    cap_addr = reg_addr_o; cap_be = reg_be_o; cap_wdata = reg_wdata_o;
  endtask

  task automatic send_frame(input logic blk, input logic [7:0] cnt, input int n,
                            input logic [7:0] cmd, input logic [7:0] al,
                            input logic [7:0] au, input logic [31:0] d);
    logic [7:0] body [7];
    body = '{cmd, al, au, d[7:0], d[15:8], d[23:16], d[31:24]};
    do_start(1'b0);
    send(blk ? 8'h85 : 8'h05);
    if (blk) send(cnt);
    for (int i = 0; i < n; i++) send(body[i]);
    do_stop();
  endtask

  task automatic read_resp(input logic blk);
    do_start(1'b0);
    send(blk ? 8'h85 : 8'h05);
    do_start(1'b1);
    for (int i = 0; i < 9; i++) begin
      rsp[i] = tx_byte_o;
      tx_req_i = 1'b1;
      @(negedge clk_i); tx_req_i = 1'b0;
    end
    do_stop();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12 wr", {31'd0, reg_wr_o}, 0);
    check("R12 rd", {31'd0, reg_rd_o}, 0);
    check("R12 addr", {18'd0, reg_addr_o}, 0);
    check("R12 wdata", reg_wdata_o, 0);
    check("R7 idle tx", {24'd0, tx_byte_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // table: R1 R2 R3 R4 R5
    for (int v = 0; v < 6; v++) begin
      send_frame(VECS[v].blk, VECS[v].cnt, int'(VECS[v].n), VECS[v].cmd,
                 VECS[v].al, VECS[v].au, VECS[v].data);
      check($sformatf("R2/R4/R5 strobe v%0d", v), {31'd0, seen_wr}, {31'd0, VECS[v].exp_wr});
      if (VECS[v].exp_wr) begin
        check($sformatf("R3 addr v%0d", v), {18'd0, cap_addr}, {18'd0, VECS[v].au[5:0], VECS[v].al});
        check($sformatf("R2 be v%0d", v), {28'd0, cap_be}, {28'd0, VECS[v].cmd[3:0]});
        check($sformatf("R1 wdata v%0d", v), cap_wdata, VECS[v].data);
      end
      read_resp(1'b0);
      check($sformatf("R4/R5 werr v%0d", v), {31'd0, rsp[0][6]}, {31'd0, !VECS[v].exp_wr});
    end

    // R6 R7 R8 R9: block read setup, masked lanes
    send_frame(1'b1, 8'd3, 3, 8'h15, 8'h20, 8'h01, 32'h0);
    check("R6 read strobe", {31'd0, seen_rd}, 1);
    check("R6 no write", {31'd0, seen_wr}, 0);
    check("R6 addr", {18'd0, cap_addr}, 32'h120);
    rd = model_rd(14'h0120);
    read_resp(1'b1);
    check("R7 count", {24'd0, rsp[0]}, 7);
    check("R8 status", {24'd0, rsp[1]}, 32'h15);
    check("R7 addr lo", {24'd0, rsp[2]}, 32'h20);
    check("R7 addr hi", {24'd0, rsp[3]}, 32'h01);
    check("R9 lane0", {24'd0, rsp[4]}, {24'd0, rd[7:0]});
    check("R9 lane1 masked", {24'd0, rsp[5]}, 0);
    check("R9 lane2", {24'd0, rsp[6]}, {24'd0, rd[23:16]});
    check("R9 lane3 masked", {24'd0, rsp[7]}, 0);
    check("R7 past end", {24'd0, rsp[8]}, 0);

    // R9 read error, R3 upper bits dropped in response
    send_frame(1'b0, 8'd0, 3, 8'h1F, 8'hFF, 8'hFF, 32'h0);
    check("R6 err read strobe", {31'd0, seen_rd}, 1);
    read_resp(1'b0);
    check("R8 R9 status rerr", {24'd0, rsp[0]}, 32'h3F);
    check("R3 addr hi resp", {24'd0, rsp[2]}, 32'h3F);
    check("R9 zero data", {rsp[6], rsp[5], rsp[4], rsp[3]}, 0);
    check("R7 non-block past end", {24'd0, rsp[7]}, 0);

    // R10 werr clears after status sent
    send_frame(1'b0, 8'd0, 2, 8'h0F, 8'h01, 8'h00, 32'h0);
    read_resp(1'b0);
    check("R10 werr set", {31'd0, rsp[0][6]}, 1);
    read_resp(1'b0);
    check("R10 werr cleared", {31'd0, rsp[0][6]}, 0);

    // R11 mid-frame start aborts, parser recovers
    do_start(1'b0);
    send(8'h05); send(8'h0F); send(8'h02);
    do_start(1'b0);
    send(8'h05); send(8'h03); send(8'h07); send(8'h00);
    send(8'hA1); send(8'hB2); send(8'hC3); send(8'hD4);
    do_stop();
    check("R11 recover strobe", {31'd0, seen_wr}, 1);
    check("R11 recover addr", {18'd0, cap_addr}, 32'h7);
    check("R11 recover data", cap_wdata, 32'hD4C3B2A1);
    read_resp(1'b0);
    check("R11 no werr on abort", {31'd0, rsp[0][6]}, 0);

    // R11 read start mid-frame does not open a response
    do_start(1'b0);
    send(8'h05); send(8'h1F);
    do_start(1'b1);
    check("R11 no response mid-frame", {24'd0, tx_byte_o}, 0);
    do_stop();
    check("R11 no strobe", {31'd0, seen_wr | seen_rd}, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule